// File: doc/BRIEF.md
# Wide Register Write Collector

This block stands between a 32-bit host write port and a bank of 128-bit control registers. The host cannot write a wide register in one transfer. So the block gathers the four 32-bit pieces of a wide register in one shared holding buffer. It releases them to the register bank as a single 128-bit commit only when every piece has arrived. While the buffer is filling, it is bound to one register address. A piece aimed at any other wide register is thrown away, and the buffer is left as it was.

Two wide registers act as doorbells. They repeat once in every 8 KiB page of the address space. A write to the highest dword of a doorbell always produces a commit. If the buffer does not already hold the three lower dwords of that same doorbell, the lower 96 bits are sent as zero. Two 32-bit registers in every page bypass the buffer and are forwarded as soon as they are written. When the quirk parameter is set, a write to one of them, the timer register in page 0, also empties the buffer.

All outputs are registered. A commit or a forwarded 32-bit write appears as a one-cycle strobe on the clock edge after the write that causes it. The strobe comes with the target address and the data.

Top module: `wide_write_collector`

## Requirements
- R1: A wide register is committed once all four of its dwords have been written, in any order. Lane k of `commit_data` (bits 32k+31:32k) is the dword written to byte offset 4k of the register. `commit_addr` is the register's 16-byte-aligned address.
- R2: No commit occurs while fewer than four dwords of a non-doorbell register have been collected.
- R3: A write to the top dword of a doorbell always commits it. A doorbell is at page offset 0x830 (top dword 0x83C) or 0xA10 (top dword 0xA1C). When the three lower dwords of that same doorbell are already held, the commit carries all four written dwords.
- R4: A doorbell commit whose lower dwords are not all held carries zero in bits 95:0 and the written value in bits 127:96.
- R5: While the buffer holds part of one register, a write to a non-top dword of a different wide register is dropped. The write produces no strobe, and the held data is later committed unchanged.
- R6: Address decoding uses the offset within an 8 KiB page (address bits 12:0). A doorbell or 32-bit register at page p sits at p*0x2000 plus its offset, and `commit_addr` carries the full address.
- R7: Writes to page offsets 0x400 and 0x420 in any page raise `pass_valid` with the same address and data one cycle later. They produce no commit, and (except as in R8) leave the buffer as it was.
- R8: With TIMER_QUIRK set, a write to offset 0x420 in page 0 empties the buffer. The same register in any other page does not.
- R9: Every commit empties the buffer, including a doorbell commit made while it held another register.
- R10: After reset, both strobes are low and the buffer is empty.
- R11: `commit_valid` rises on the clock edge after the completing write and stays high for that single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host dword write valid |
| wr_addr | input | ADDR_W | Byte address of the dword |
| wr_data | input | DW | Dword value |
| commit_valid | output | 1 | One-cycle wide commit strobe |
| commit_addr | output | ADDR_W | Aligned address of the committed register |
| commit_data | output | DW*LANES | Committed 128-bit value |
| pass_valid | output | 1 | One-cycle 32-bit forward strobe |
| pass_addr | output | ADDR_W | Address of the forwarded write |
| pass_data | output | DW | Value of the forwarded write |

## Verification
Two pairs of functions can act on one write. In the first pair, the doorbell top-dword rule and the buffer's foreign-address drop rule both apply when a doorbell's top dword arrives while the buffer holds part of another register. The bench sets this up and expects a zero-filled commit. It then confirms that the buffer was emptied: it completes the earlier register partly and expects no commit, then completes it fully with new data. In the second pair, a 32-bit forward and a buffer flush come from the same page-0 timer write. The bench judges this by the forward strobe, and then by whether a later lone top dword still completes the old register.

// File: rtl/wc_pkg.sv
package wc_pkg;

  typedef enum logic [1:0] {
    K_WIDE     = 2'd0,
    K_DOORBELL = 2'd1,
    K_NARROW   = 2'd2
  } wkind_e;

  // true when ofs lies in [start, start+len)
  function automatic logic in_window(input int unsigned ofs,
                                     input int unsigned start,
                                     input int unsigned len);
    return (ofs >= start) && (ofs < start + len);
  endfunction

  // one-hot lane select
  function automatic logic [3:0] lane_hot(input logic [1:0] lane);
    return 4'b0001 << lane;
  endfunction

endpackage

// File: rtl/wc_decode.sv
module wc_decode
  import wc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_SHIFT  = 13,
  parameter int LOW_W       = 4,
  parameter int BYTE_SH     = 2,
  parameter int unsigned DB0_OFS = 32'h830,
  parameter int unsigned DB1_OFS = 32'hA10,
  parameter int unsigned EVQ_OFS = 32'h400,
  parameter int unsigned TMR_OFS = 32'h420,
  parameter bit TIMER_QUIRK = 1'b1
) (
  input  logic [ADDR_W-1:0]        addr,
  output wkind_e                   kind,
  output logic                     is_top,
  output logic [ADDR_W-1:0]        base,
  output logic [LOW_W-BYTE_SH-1:0] lane,
  output logic                     kill
);
  localparam int unsigned REG_BYTES = 1 << LOW_W;
  localparam int LANE_W = LOW_W - BYTE_SH;

  logic [31:0] pg_ofs;
  logic        page_zero;
  logic        db_hit;
  logic        narrow_hit;

  assign pg_ofs     = 32'(addr[PAGE_SHIFT-1:0]);
  assign page_zero  = (addr[ADDR_W-1:PAGE_SHIFT] == '0);
  assign db_hit     = in_window(pg_ofs, DB0_OFS, REG_BYTES) ||
                      in_window(pg_ofs, DB1_OFS, REG_BYTES);
  assign narrow_hit = (pg_ofs == EVQ_OFS) || (pg_ofs == TMR_OFS);

  assign base   = {addr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
  assign lane   = addr[LOW_W-1:BYTE_SH];
  assign is_top = (lane == {LANE_W{1'b1}});
  assign kill   = TIMER_QUIRK && page_zero && (pg_ofs == TMR_OFS);

  always_comb begin
    if (narrow_hit)  kind = K_NARROW;
    else if (db_hit) kind = K_DOORBELL;
    else             kind = K_WIDE;
  end
endmodule

// File: rtl/wc_collector.sv
module wc_collector
  import wc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DW     = 32,
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  wkind_e                kind,
  input  logic                  is_top,
  input  logic [ADDR_W-1:0]     base,
  input  logic [LANE_W-1:0]     lane,
  input  logic                  kill,
  input  logic [DW-1:0]         data,
  output logic                  cm_vld,
  output logic [ADDR_W-1:0]     cm_addr,
  output logic [DW*LANES-1:0]   cm_data
);
  logic [ADDR_W-1:0]           hold_base;
  logic [LANES-1:0]            hold_mask;
  logic [LANES-1:0][DW-1:0]    store;
  logic [LANES-1:0][DW-1:0]    assembled;
  logic [LANES-1:0]            lane_bit;
  logic [LANES-1:0]            merged;

  // named internal events
  logic wide_hit, busy, same, accept, full, db_fire, fire, drop;

  assign lane_bit = LANES'(1) << lane;
  assign wide_hit = wr_en && (kind != K_NARROW);
  assign busy     = |hold_mask;
  assign same     = (hold_base == base);
  assign accept   = wide_hit && (!busy || same);
  assign merged   = hold_mask | lane_bit;
  assign full     = accept && (&merged);
  assign db_fire  = wide_hit && (kind == K_DOORBELL) && is_top;
  assign fire     = full || db_fire;
  assign drop     = wide_hit && !accept && !db_fire;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (lane == LANE_W'(i))            assembled[i] = data;
      else if (db_fire && !full)         assembled[i] = '0;
      else                               assembled[i] = store[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                               store[i] <= '0;
      else if (accept && lane == LANE_W'(i))    store[i] <= data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_mask <= '0;
      hold_base <= '0;
      cm_vld    <= 1'b0;
      cm_addr   <= '0;
      cm_data   <= '0;
    end else begin
      cm_vld <= fire;
      if (fire) begin
        cm_addr <= base;
        cm_data <= assembled;
      end
      if (fire || (wr_en && kill)) begin
        hold_mask <= '0;
      end else if (accept) begin
        hold_mask <= merged;
        hold_base <= base;
      end
    end
  end

  // R5
  drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ($stable(hold_mask) && $stable(hold_base) && !cm_vld));
  // R3
  db_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_fire |=> cm_vld);
  // R9
  clear_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_vld |-> (hold_mask == '0));
  // R11
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_vld |-> $past(wr_en));
endmodule

// File: rtl/wc_passthru.sv
module wc_passthru #(
  parameter int ADDR_W = 16,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     data,
  output logic              p_vld,
  output logic [ADDR_W-1:0] p_addr,
  output logic [DW-1:0]     p_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld  <= 1'b0;
      p_addr <= '0;
      p_data <= '0;
    end else begin
      p_vld <= take;
      if (take) begin
        p_addr <= addr;
        p_data <= data;
      end
    end
  end

  // R7
  pass_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_vld |-> $past(take));
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
  import wc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DW          = 32,
  parameter int LANES       = 4,
  parameter int PAGE_SHIFT  = 13,
  parameter int unsigned DB0_OFS = 32'h830,
  parameter int unsigned DB1_OFS = 32'hA10,
  parameter int unsigned EVQ_OFS = 32'h400,
  parameter int unsigned TMR_OFS = 32'h420,
  parameter bit TIMER_QUIRK = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DW-1:0]       wr_data,
  output logic                commit_valid,
  output logic [ADDR_W-1:0]   commit_addr,
  output logic [DW*LANES-1:0] commit_data,
  output logic                pass_valid,
  output logic [ADDR_W-1:0]   pass_addr,
  output logic [DW-1:0]       pass_data
);
  localparam int BYTE_SH = $clog2(DW / 8);
  localparam int LANE_W  = $clog2(LANES);
  localparam int LOW_W   = BYTE_SH + LANE_W;

  wkind_e              kind;
  logic                is_top;
  logic [ADDR_W-1:0]   base;
  logic [LANE_W-1:0]   lane;
  logic                kill;
  logic                narrow_take;

  wc_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .LOW_W(LOW_W), .BYTE_SH(BYTE_SH),
    .DB0_OFS(DB0_OFS), .DB1_OFS(DB1_OFS), .EVQ_OFS(EVQ_OFS), .TMR_OFS(TMR_OFS),
    .TIMER_QUIRK(TIMER_QUIRK)
  ) u_dec (
    .addr(wr_addr), .kind(kind), .is_top(is_top), .base(base),
    .lane(lane), .kill(kill)
  );

  wc_collector #(.ADDR_W(ADDR_W), .DW(DW), .LANES(LANES)) u_col (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .kind(kind), .is_top(is_top),
    .base(base), .lane(lane), .kill(kill), .data(wr_data),
    .cm_vld(commit_valid), .cm_addr(commit_addr), .cm_data(commit_data)
  );

  assign narrow_take = wr_en && (kind == K_NARROW);

  wc_passthru #(.ADDR_W(ADDR_W), .DW(DW)) u_pass (
    .clk(clk), .rst_n(rst_n), .take(narrow_take), .addr(wr_addr),
    .data(wr_data), .p_vld(pass_valid), .p_addr(pass_addr), .p_data(pass_data)
  );

  // R7
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_valid && pass_valid));
endmodule

// File: tb/tb_wide_write_collector.sv
module tb_wide_write_collector;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [15:0]  wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         commit_valid;
  logic [15:0]  commit_addr;
  logic [127:0] commit_data;
  logic         pass_valid;
  logic [15:0]  pass_addr;
  logic [31:0]  pass_data;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wide_write_collector dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_valid(commit_valid), .commit_addr(commit_addr),
    .commit_data(commit_data), .pass_valid(pass_valid), .pass_addr(pass_addr),
    .pass_data(pass_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one write; returns at the negedge where its registered effect is visible
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_commit(input string req, input logic [15:0] a,
                               input logic [127:0] d);
    chk(req, "commit_valid", 128'(commit_valid), 128'(1));
    chk(req, "commit_addr", 128'(commit_addr), 128'(a));
    chk(req, "commit_data", commit_data, d);
  endtask

  task automatic t_reset;
    chk("R10", "commit_valid after reset", 128'(commit_valid), 128'(0));
    chk("R10", "pass_valid after reset", 128'(pass_valid), 128'(0));
  endtask

  task automatic t_normal;
    wr(16'h0108, 32'hA2A2_0002);
    chk("R2", "no commit after 1 dword", 128'(commit_valid), 128'(0));
    wr(16'h0100, 32'hA0A0_0000);
    wr(16'h010C, 32'hA3A3_0003);
    chk("R2", "no commit after 3 dwords", 128'(commit_valid), 128'(0));
    wr(16'h0104, 32'hA1A1_0001);
    expect_commit("R1", 16'h0100,
      {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000});
    @(negedge clk);
    chk("R11", "strobe is one cycle", 128'(commit_valid), 128'(0));
  endtask

  task automatic t_discard_normal;
    wr(16'h0200, 32'h1111_0000);
    wr(16'h0204, 32'h1111_0001);
    wr(16'h0300, 32'hBAD0_BAD0);
    chk("R5", "foreign wide write dropped", 128'(commit_valid), 128'(0));
    wr(16'h0208, 32'h1111_0002);
    wr(16'h020C, 32'h1111_0003);
    expect_commit("R5", 16'h0200,
      {32'h1111_0003, 32'h1111_0002, 32'h1111_0001, 32'h1111_0000});
    wr(16'h0300, 32'h3000_0000);
    wr(16'h0304, 32'h3000_0001);
    wr(16'h0308, 32'h3000_0002);
    wr(16'h030C, 32'h3000_0003);
    expect_commit("R9", 16'h0300,
      {32'h3000_0003, 32'h3000_0002, 32'h3000_0001, 32'h3000_0000});
  endtask

  task automatic t_doorbell;
    wr(16'h083C, 32'hD00D_0001);
    expect_commit("R4", 16'h0830, {32'hD00D_0001, 96'h0});
    wr(16'h4A10, 32'hE000_0000);
    wr(16'h4A14, 32'hE000_0001);
    wr(16'h4A18, 32'hE000_0002);
    chk("R2", "doorbell lower dwords wait", 128'(commit_valid), 128'(0));
    wr(16'h4A1C, 32'hE000_0003);
    expect_commit("R6", 16'h4A10,
      {32'hE000_0003, 32'hE000_0002, 32'hE000_0001, 32'hE000_0000});
    wr(16'h0834, 32'h5555_5555);
    wr(16'h083C, 32'hD00D_0002);
    expect_commit("R4", 16'h0830, {32'hD00D_0002, 96'h0});
    wr(16'h2A1C, 32'hD00D_0003);
    expect_commit("R3", 16'h2A10, {32'hD00D_0003, 96'h0});
  endtask

  task automatic t_doorbell_overlap;
    wr(16'h0100, 32'h7000_0000);
    wr(16'h0104, 32'h7000_0001);
    wr(16'h0834, 32'hBAD1_BAD1);
    chk("R5", "doorbell low dword dropped", 128'(commit_valid), 128'(0));
    wr(16'h083C, 32'hD00D_0004);
    expect_commit("R3", 16'h0830, {32'hD00D_0004, 96'h0});
    wr(16'h0108, 32'h7100_0002);
    wr(16'h010C, 32'h7100_0003);
    chk("R9", "held dwords gone after doorbell", 128'(commit_valid), 128'(0));
    wr(16'h0100, 32'h7100_0000);
    wr(16'h0104, 32'h7100_0001);
    expect_commit("R9", 16'h0100,
      {32'h7100_0003, 32'h7100_0002, 32'h7100_0001, 32'h7100_0000});
  endtask

  task automatic t_narrow;
    wr(16'h6400, 32'hEEEE_0400);
    chk("R7", "pass_valid", 128'(pass_valid), 128'(1));
    chk("R7", "pass_addr", 128'(pass_addr), 128'(16'h6400));
    chk("R7", "pass_data", 128'(pass_data), 128'(32'hEEEE_0400));
    chk("R7", "no commit on narrow", 128'(commit_valid), 128'(0));
    wr(16'h0500, 32'h5000_0000);
    wr(16'h0504, 32'h5000_0001);
    wr(16'h0508, 32'h5000_0002);
    wr(16'h0400, 32'hEEEE_0401);
    chk("R7", "pass amid collection", 128'(pass_valid), 128'(1));
    wr(16'h050C, 32'h5000_0003);
    expect_commit("R7", 16'h0500,
      {32'h5000_0003, 32'h5000_0002, 32'h5000_0001, 32'h5000_0000});
  endtask

  task automatic t_timer;
    wr(16'h0600, 32'h6000_0000);
    wr(16'h0604, 32'h6000_0001);
    wr(16'h0608, 32'h6000_0002);
    wr(16'h2420, 32'h7171_0001);
    chk("R8", "timer page 1 forwarded", 128'(pass_valid), 128'(1));
    wr(16'h060C, 32'h6000_0003);
    expect_commit("R8", 16'h0600,
      {32'h6000_0003, 32'h6000_0002, 32'h6000_0001, 32'h6000_0000});
    wr(16'h0700, 32'h7700_0000);
    wr(16'h0704, 32'h7700_0001);
    wr(16'h0708, 32'h7700_0002);
    wr(16'h0420, 32'h7171_0000);
    chk("R8", "timer page 0 forwarded", 128'(pass_valid), 128'(1));
    chk("R8", "timer page 0 pass_addr", 128'(pass_addr), 128'(16'h0420));
    wr(16'h070C, 32'h7700_0003);
    chk("R8", "flushed buffer does not commit", 128'(commit_valid), 128'(0));
    wr(16'h0700, 32'h7800_0000);
    wr(16'h0704, 32'h7800_0001);
    wr(16'h0708, 32'h7800_0002);
    expect_commit("R8", 16'h0700,
      {32'h7700_0003, 32'h7800_0002, 32'h7800_0001, 32'h7800_0000});
  endtask

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_discard_normal();
    t_doorbell();
    t_doorbell_overlap();
    t_narrow();
    t_timer();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule